// File: doc/BRIEF.md
# Read-Return Data Buffer with Burst Tracking

This block sits between the bus side of a bus-mastering read engine and the application logic that consumes the returned data. Returned 64-bit beats are written into a small first-in first-out store of thirty-two entries, which holds sixty-four 32-bit words. The application pulls beats out with an active-low read strobe. A separate select input blocks reads while it is high. The head entry is always visible on the output, so the word read on a given edge is the one presented during that cycle.

Before each transaction a planner loads the number of beats the application should expect. The planner also states whether the access is a single 32-bit word and which half of the beat holds that word. A down-counter follows the accepted reads. It drives an active-low last-beat marker, and for single-word accesses it moves the valid half to the low lane. The block drives active-low empty and almost-empty flags from registers. These flags update on the same edge that accepts a read or a write. A read while empty, or a write while full, is dropped and sets a sticky error bit.

Top module: `mrd_fifo`

## Requirements
- R1: The store holds exactly DEPTH (32) beats. A write while 32 beats are held is dropped, sets `ovf_o` to 1 from the next cycle on, and leaves the stored contents unchanged.
- R2: A read is accepted on a rising edge only when `rd_en_ni` = 0 and `fifo_sel_i` = 0. With `fifo_sel_i` = 1 nothing is popped. Beats leave in write order, and the head beat is shown on `rd_data_o` during the cycle in which it is read.
- R3: `aempty_no` is 0 whenever 4 or fewer beats are held and 1 otherwise. It is registered and reflects the fill level after each edge.
- R4: `empty_no` is 0 exactly when no beat is held. A read while empty pops nothing, sets `unf_o` to 1 from the next cycle on, and does not disturb the order of later data.
- R5: `last_no` is 0 only while a read is requested (`rd_en_ni` = 0, `fifo_sel_i` = 0) and one beat of the current transaction remains. During a burst it is 1 for every earlier beat.
- R6: For a single-word transaction (count 1), `last_no` is 0 for the whole data phase, which means every cycle the read is requested.
- R7: When `txn_single_i` = 1 is loaded, `rd_data_o[31:0]` carries the upper half of the head beat if `txn_hi_i` = 1 and the lower half otherwise, and `rd_data_o[63:32]` is 0. For burst transactions `rd_data_o` is the unchanged 64-bit beat.
- R8: A write and an accepted read on the same edge leave the fill level, and so both flags, unchanged, and both transfers take effect.
- R9: `txn_start_i` loads the remaining-beat counter with `txn_count_i`. Each accepted read lowers the counter by one, and the counter stops at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe from the bus side |
| wr_data_i | input | 64 | Returned beat |
| txn_start_i | input | 1 | Load the transaction descriptor |
| txn_count_i | input | 6 | Beats expected in the transaction |
| txn_single_i | input | 1 | Transaction is a single 32-bit word |
| txn_hi_i | input | 1 | Single word sits in the upper half of the beat |
| rd_en_ni | input | 1 | Read strobe, active low |
| fifo_sel_i | input | 1 | Blocks reads when high |
| rd_data_o | output | 64 | Head beat, or the aligned single word |
| empty_no | output | 1 | Empty flag, active low |
| aempty_no | output | 1 | Almost-empty flag, active low |
| last_no | output | 1 | Last-beat marker, active low |
| ovf_o | output | 1 | Sticky overflow error |
| unf_o | output | 1 | Sticky underflow error |

## Verification
The fill level is swept one beat at a time from empty to full and then drained one beat at a time. This locates both flag thresholds exactly and shows that an overflowing write leaves no trace in the drained data. Bursts of every length from one to six separate a last-beat marker that counts correctly from one that is early or late by a beat. Single-word transactions with each half selected check the lane steering, and blocked-select cycles and empty reads show that nothing is popped in those cases. A stretch of simultaneous writes and reads shows that the level is held and the data order is kept.

// File: rtl/mrd_fifo_pkg.sv
package mrd_fifo_pkg;
  localparam int unsigned BEAT_W = 64;
  localparam int unsigned HALF_W = BEAT_W / 2;

  function automatic logic [BEAT_W-1:0] steer_beat(input logic [BEAT_W-1:0] beat,
                                                   input logic single, input logic hi);
    logic [BEAT_W-1:0] r;
    if (!single)  r = beat;
    else if (hi)  r = {{HALF_W{1'b0}}, beat[BEAT_W-1:HALF_W]};
    else          r = {{HALF_W{1'b0}}, beat[HALF_W-1:0]};
    return r;
  endfunction
endpackage

// File: rtl/mrd_fifo_store.sv
module mrd_fifo_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             rd_i,
  output logic [W-1:0]     head_o,
  output logic [LVL_W-1:0] level_o,
  output logic [LVL_W-1:0] level_d_o,
  output logic             wr_drop_o,
  output logic             rd_drop_o,
  output logic             rd_acc_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [LVL_W-1:0] lvl_q;
  logic             full, empty, wr_acc;

  assign full      = (lvl_q == LVL_W'(DEPTH));
  assign empty     = (lvl_q == '0);
  assign wr_acc    = wr_i & ~full;
  assign rd_acc_o  = rd_i & ~empty;
  assign wr_drop_o = wr_i & full;
  assign rd_drop_o = rd_i & empty;
  assign head_o    = mem[rp_q];
  assign level_o   = lvl_q;

  always_comb begin
    level_d_o = lvl_q;
    if (wr_acc && !rd_acc_o)      level_d_o = lvl_q + 1'b1;
    else if (!wr_acc && rd_acc_o) level_d_o = lvl_q - 1'b1;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_acc) mem[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_acc)   wp_q <= bump(wp_q);
      if (rd_acc_o) rp_q <= bump(rp_q);
      lvl_q <= level_d_o;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && wr_i && !rd_i |=> (lvl_q == LVL_W'(DEPTH)) && $stable(wp_q)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty && rd_i |=> $stable(rp_q)); // R4
  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && rd_i && !full && !empty |=> $stable(lvl_q)); // R8
endmodule

// File: rtl/mrd_fifo_flags.sv
module mrd_fifo_flags #(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned AEMPTY_LVL = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] level_d_i,
  input  logic             wr_drop_i,
  input  logic             rd_drop_i,
  output logic             empty_no,
  output logic             aempty_no,
  output logic             ovf_o,
  output logic             unf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_no  <= 1'b0;
      aempty_no <= 1'b0;
      ovf_o     <= 1'b0;
      unf_o     <= 1'b0;
    end else begin
      empty_no  <= (level_d_i != '0);
      aempty_no <= (level_d_i > LVL_W'(AEMPTY_LVL));
      ovf_o     <= ovf_o | wr_drop_i;
      unf_o     <= unf_o | rd_drop_i;
    end
  end

  AST_EMPTY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_no == (level_i != '0)); // R4
  AST_AEMPTY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aempty_no == (level_i > LVL_W'(AEMPTY_LVL))); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R1
  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o); // R4
endmodule

// File: rtl/mrd_fifo_track.sv
module mrd_fifo_track
  import mrd_fifo_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic [CNT_W-1:0]  txn_count_i,
  input  logic              txn_single_i,
  input  logic              txn_hi_i,
  input  logic              rd_req_i,
  input  logic              rd_acc_i,
  input  logic [BEAT_W-1:0] head_i,
  output logic [BEAT_W-1:0] rd_data_o,
  output logic              last_no
);
  logic [CNT_W-1:0] remain_q;
  logic             single_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      single_q <= 1'b0;
      hi_q     <= 1'b0;
    end else if (txn_start_i) begin
      remain_q <= txn_count_i;
      single_q <= txn_single_i;
      hi_q     <= txn_hi_i;
    end else if (rd_acc_i && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign last_no   = ~(rd_req_i && remain_q == CNT_W'(1));
  assign rd_data_o = steer_beat(head_i, single_q, hi_q);

  AST_REMAIN_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc_i && !txn_start_i && remain_q != '0 |=> remain_q == $past(remain_q) - 1'b1); // R9
  AST_REMAIN_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_start_i && remain_q == '0 |=> remain_q == '0); // R9
  AST_LAST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_no |-> rd_req_i); // R5
endmodule

// File: rtl/mrd_fifo.sv
module mrd_fifo
  import mrd_fifo_pkg::*;
#(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned AEMPTY_LVL = 4,
  parameter int unsigned CNT_W      = 6,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BEAT_W-1:0] wr_data_i,
  input  logic              txn_start_i,
  input  logic [CNT_W-1:0]  txn_count_i,
  input  logic              txn_single_i,
  input  logic              txn_hi_i,
  input  logic              rd_en_ni,
  input  logic              fifo_sel_i,
  output logic [BEAT_W-1:0] rd_data_o,
  output logic              empty_no,
  output logic              aempty_no,
  output logic              last_no,
  output logic              ovf_o,
  output logic              unf_o
);
  logic              rd_req, rd_acc, wr_drop, rd_drop;
  logic [BEAT_W-1:0] head;
  logic [LVL_W-1:0]  level, level_d;

  assign rd_req = ~rd_en_ni & ~fifo_sel_i;

  mrd_fifo_store #(.DEPTH(DEPTH), .W(BEAT_W)) u_store (
    .clk_i, .rst_ni, .wr_i(wr_en_i), .wr_data_i, .rd_i(rd_req),
    .head_o(head), .level_o(level), .level_d_o(level_d),
    .wr_drop_o(wr_drop), .rd_drop_o(rd_drop), .rd_acc_o(rd_acc)
  );

  mrd_fifo_flags #(.DEPTH(DEPTH), .AEMPTY_LVL(AEMPTY_LVL)) u_flags (
    .clk_i, .rst_ni, .level_i(level), .level_d_i(level_d),
    .wr_drop_i(wr_drop), .rd_drop_i(rd_drop),
    .empty_no, .aempty_no, .ovf_o, .unf_o
  );

  mrd_fifo_track #(.CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni, .txn_start_i, .txn_count_i, .txn_single_i, .txn_hi_i,
    .rd_req_i(rd_req), .rd_acc_i(rd_acc), .head_i(head),
    .rd_data_o, .last_no
  );

  AST_SEL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_sel_i && !wr_en_i |=> $stable(empty_no) && $stable(aempty_no)); // R2
endmodule

// File: tb/mrd_fifo_tb_top.sv
module mrd_fifo_tb_top;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        txn_start = 1'b0;
  logic [5:0]  txn_count = '0;
  logic        txn_single = 1'b0;
  logic        txn_hi = 1'b0;
  logic        rd_en_n = 1'b1;
  logic        fifo_sel = 1'b0;
  logic [63:0] rd_data;
  logic        empty_n, aempty_n, last_n, ovf, unf;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrd_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .txn_start_i(txn_start), .txn_count_i(txn_count), .txn_single_i(txn_single),
    .txn_hi_i(txn_hi), .rd_en_ni(rd_en_n), .fifo_sel_i(fifo_sel),
    .rd_data_o(rd_data), .empty_no(empty_n), .aempty_no(aempty_n),
    .last_no(last_n), .ovf_o(ovf), .unf_o(unf)
  );

  function automatic logic [63:0] beat(input int i);
    return {32'(i) + 32'hC0DE_0000, 32'(i) ^ 32'h0000_5A5A};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input int lvl, input string req);
    chk(empty_n == (lvl != 0), req, 64'(empty_n), 64'(lvl != 0));
    chk(aempty_n == (lvl > 4), req, 64'(aempty_n), 64'(lvl > 4));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [63:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start(input int n, input bit single, input bit hi);
    txn_start = 1'b1; txn_count = 6'(n); txn_single = single; txn_hi = hi;
    @(negedge clk);
    txn_start = 1'b0;
  endtask

  // reads n beats with first index base; lvl is the level before reading
  task automatic drain(input int n, input int base, input int lvl);
    for (int i = 0; i < n; i++) begin
      chk_flags(lvl - i, "R3/R4 drain");
      rd_en_n = 1'b0;
      #1;
      chk(rd_data == beat(base + i), "R2 order", rd_data, beat(base + i));
      chk(last_n == (i != n - 1), "R5 last", 64'(last_n), 64'(i != n - 1));
      @(negedge clk);
    end
    rd_en_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'(0), 64'(1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    #1;
    chk(empty_n == 1'b0 && aempty_n == 1'b0, "R4 reset flags", {empty_n, aempty_n}, 64'(0));
    chk(last_n == 1'b1 && ovf == 1'b0 && unf == 1'b0, "R5 reset", {last_n, ovf, unf}, 64'b100);
    do_reset();

    // R1 R3 R4 fill sweep
    for (int k = 1; k <= 32; k++) begin
      push(beat(k - 1));
      chk_flags(k, "R3/R4 fill");
    end
    chk(ovf == 1'b0, "R1 no ovf at full", 64'(ovf), 64'(0));
    push(beat(99));
    chk(ovf == 1'b1, "R1 ovf set", 64'(ovf), 64'(1));
    chk_flags(32, "R1 level held");
    start(32, 1'b0, 1'b0);
    drain(32, 0, 32);
    chk_flags(0, "R4 empty after drain");

    // R4 empty read ignored
    rd_en_n = 1'b0;
    @(negedge clk);
    rd_en_n = 1'b1;
    chk(unf == 1'b1, "R4 unf set", 64'(unf), 64'(1));
    chk_flags(0, "R4 empty held");
    push(beat(200));
    push(beat(201));
    start(2, 1'b0, 1'b0);
    drain(2, 200, 2);

    // R5 R9 bursts of every length
    do_reset();
    for (int n = 1; n <= 6; n++) begin
      for (int j = 0; j < n; j++) push(beat(10 * n + j));
      start(n, 1'b0, 1'b0);
      drain(n, 10 * n, n);
      // R9 counter floor: extra read requested with empty FIFO keeps last_n high
      fifo_sel = 1'b0; rd_en_n = 1'b0; #1;
      chk(last_n == 1'b1, "R9 floor", 64'(last_n), 64'(1));
      rd_en_n = 1'b1;
      do_reset();
    end

    // R2 fifo_sel blocks reads
    push(beat(300));
    push(beat(301));
    start(2, 1'b0, 1'b0);
    fifo_sel = 1'b1; rd_en_n = 1'b0;
    #1;
    chk(last_n == 1'b1, "R2 sel no last", 64'(last_n), 64'(1));
    repeat (3) @(negedge clk);
    fifo_sel = 1'b0; rd_en_n = 1'b1;
    chk_flags(2, "R2 sel no pop");
    drain(2, 300, 2);

    // R6 R7 single-word with each half
    for (int h = 0; h < 2; h++) begin
      push(beat(400 + h));
      start(1, 1'b1, h[0]);
      #1;
      chk(last_n == 1'b1, "R5 idle no last", 64'(last_n), 64'(1));
      for (int c = 0; c < 2; c++) begin
        // hold a blocked cycle then a real read: marker low whenever requested
        fifo_sel = (c == 0); rd_en_n = 1'b0;
        #1;
        chk(last_n == (c == 0), "R6 single last", 64'(last_n), 64'(c == 0));
        chk(rd_data == (h ? {32'h0, beat(400 + h)[63:32]} : {32'h0, beat(400 + h)[31:0]}),
            "R7 steer", rd_data, h ? {32'h0, beat(400 + h)[63:32]} : {32'h0, beat(400 + h)[31:0]});
        @(negedge clk);
      end
      rd_en_n = 1'b1; fifo_sel = 1'b0;
      chk_flags(0, "R6 single popped");
    end

    // R8 simultaneous write and read
    do_reset();
    for (int j = 0; j < 6; j++) push(beat(500 + j));
    start(20, 1'b0, 1'b0);
    for (int j = 0; j < 8; j++) begin
      wr_en = 1'b1; wr_data = beat(506 + j); rd_en_n = 1'b0;
      #1;
      chk(rd_data == beat(500 + j), "R8 order", rd_data, beat(500 + j));
      @(negedge clk);
      chk_flags(6, "R8 level held");
    end
    wr_en = 1'b0; rd_en_n = 1'b1;
    start(6, 1'b0, 1'b0);
    drain(6, 508, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule